// File: doc/BRIEF.md
# Audio Baud-Rate Clock Generator

The block holds two independent baud-rate generators, A and B, each producing a divided audio bit or master clock from one of four audio master clock inputs. The inputs arrive as single-cycle enable ticks in the system clock domain, one tick per period of the external clock. Each generator picks its input through a 3-bit source code in a shared control register. It divides by a 10-bit ratio built from a coarse power-of-four prescaler (x2, x8, x32 or x128) cascaded with an 8-bit counter that stores the count minus one. Generator A is intended for the 44.1 kHz rate family and generator B for the 48 kHz family.

Software programs the block through a plain write port with three registers: control at address 0, ratio A at address 1 and ratio B at address 2. The output of each generator is a one-cycle enable pulse, once per completed division. A new ratio is held aside and only takes over at the next terminal count, so a reprogrammed generator never emits a shortened period. An unlisted source code gates the generator quiet.

Top module: `aud_baud_gen`

## Requirements
- R1: After reset both outputs are low, both ratio registers hold 2 (prescale code 0, N=2, divide by 6) and both source codes are 0.
- R2: A ratio value carries the prescale code i in bits 9:8 and N in bits 7:0; the generator pulses once every (2 << 2*i) * (N+1) ticks of its selected input.
- R3: The control register source field for generator A is bits 22:20 and for generator B bits 18:16; every other control bit is ignored.
- R4: Source code 0 selects src_tick[0], code 1 selects src_tick[1], code 4 selects src_tick[2] and code 2 selects src_tick[3]; a pulse only follows a cycle in which the selected input ticked.
- R5: Source codes 3, 5, 6 and 7 gate the generator: no input ticks are counted and its output stays low; the count so far is kept.
- R6: A written ratio takes effect at the next terminal count; a write landing in the same cycle as the terminal count is the one loaded.
- R7: Each output pulse lasts one cycle and rises one clock after the edge at which the terminal input tick was sampled.
- R8: The two generators run independently; writes to one ratio never alter the other generator's output.
- R9: Writes to address 3 are ignored; a source code change applies from the next sampled input tick without clearing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 ratio A, 2 ratio B |
| wr_data | input | 32 | Write data |
| src_tick | input | 4 | Input clock enables, one tick per external clock period |
| tick_out | output | 2 | Divided output pulses, bit 0 generator A, bit 1 generator B |

## Verification
The assertions take the input ticks and the write port to be synchronous to clk and stable around its rising edge, and they rebuild each generator's source code from the write port alone. The bench therefore changes every input on the falling edge and never pulses an input faster than once per cycle. Its stimulus mixes dense and sparse tick patterns on each input, so a mis-mapped source code or a wrong prescale shows up as a shifted pulse.

// File: rtl/aud_baud_pkg.sv
`timescale 1ns/1ps
package aud_baud_pkg;
  localparam int unsigned PRE_CODE_W = 2;
  localparam int unsigned FINE_W     = 8;
  localparam int unsigned RATIO_W    = PRE_CODE_W + FINE_W;
  localparam int unsigned PRE_CNT_W  = 2 * ((2 ** PRE_CODE_W) - 1) + 1;
  localparam int unsigned SRC_CODE_W = 3;
  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned SRC_IDX_W  = $clog2(NUM_SRC);

  typedef struct packed {
    logic [PRE_CODE_W-1:0] pre_code;
    logic [FINE_W-1:0]     fine;
  } ratio_t;

  localparam ratio_t RATIO_RST = '{pre_code: '0, fine: FINE_W'(2)};

  typedef struct packed {
    logic                 ok;
    logic [SRC_IDX_W-1:0] idx;
  } src_map_t;

  function automatic src_map_t map_src(input logic [SRC_CODE_W-1:0] code);
    src_map_t m;
    m.ok  = 1'b1;
    m.idx = '0;
    case (code)
      3'd0:    m.idx = SRC_IDX_W'(0);
      3'd1:    m.idx = SRC_IDX_W'(1);
      3'd4:    m.idx = SRC_IDX_W'(2);
      3'd2:    m.idx = SRC_IDX_W'(3);
      default: m.ok  = 1'b0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/aud_baud_regs.sv
`timescale 1ns/1ps
module aud_baud_regs
  import aud_baud_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned NUM_GEN    = 2,
  parameter int unsigned SEL_HI_LSB = 20,
  parameter int unsigned SEL_STRIDE = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  output logic [NUM_GEN-1:0][SRC_CODE_W-1:0]   sel_code,
  output ratio_t [NUM_GEN-1:0]                 ratio_pend
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic unused_bits;
  assign unused_bits = ^wr_data;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int unsigned SEL_LSB = SEL_HI_LSB - g * SEL_STRIDE;
    localparam logic [ADDR_W-1:0] RATIO_ADDR = ADDR_W'(g + 1);

    logic   [SRC_CODE_W-1:0] sel_q;
    ratio_t                  ratio_q;
    ratio_t                  ratio_d;
    logic                    ratio_wr;

    assign ratio_wr = wr_en && (wr_addr == RATIO_ADDR);

    always_comb begin
      ratio_d = ratio_q;
      if (ratio_wr) ratio_d = ratio_t'(wr_data[RATIO_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q   <= '0;
        ratio_q <= RATIO_RST;
      end else begin
        if (ctrl_wr) sel_q <= wr_data[SEL_LSB +: SRC_CODE_W];
        ratio_q <= ratio_d;
      end
    end

    assign sel_code[g]   = sel_q;
    assign ratio_pend[g] = ratio_d;
  end
endmodule

// File: rtl/aud_baud_src_sel.sv
`timescale 1ns/1ps
module aud_baud_src_sel
  import aud_baud_pkg::*;
(
  input  logic [NUM_SRC-1:0]    src_tick,
  input  logic [SRC_CODE_W-1:0] sel_code,
  output logic                  tick_en
);
  src_map_t m;
  always_comb begin
    m       = map_src(sel_code);
    tick_en = m.ok && src_tick[m.idx];
  end
endmodule

// File: rtl/aud_baud_div.sv
`timescale 1ns/1ps
module aud_baud_div
  import aud_baud_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_en,
  input  ratio_t ratio_pend,
  output logic   pulse
);
  ratio_t               act_q;
  logic [PRE_CNT_W-1:0] pre_q;
  logic [PRE_CNT_W-1:0] pre_last;
  logic [PRE_CNT_W:0]   pre_div;
  logic [FINE_W-1:0]    fine_q;
  logic                 pre_wrap;
  logic                 term;

  always_comb begin
    pre_div  = (PRE_CNT_W + 1)'(2) << {act_q.pre_code, 1'b0};
    pre_last = PRE_CNT_W'(pre_div - 1'b1);
    pre_wrap = tick_en && (pre_q == pre_last);
    term     = pre_wrap && (fine_q == act_q.fine);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= RATIO_RST;
      pre_q  <= '0;
      fine_q <= '0;
      pulse  <= 1'b0;
    end else begin
      pulse <= term;
      if (tick_en) begin
        if (pre_wrap) begin
          pre_q <= '0;
          if (term) begin
            fine_q <= '0;
            act_q  <= ratio_pend;
          end else begin
            fine_q <= fine_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aud_baud_gen.sv
`timescale 1ns/1ps
module aud_baud_gen
  import aud_baud_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned NUM_GEN    = 2,
  parameter int unsigned SEL_HI_LSB = 20,
  parameter int unsigned SEL_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [NUM_GEN-1:0] tick_out
);
  logic   [NUM_GEN-1:0][SRC_CODE_W-1:0] sel_code;
  ratio_t [NUM_GEN-1:0]                 ratio_pend;

  aud_baud_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_GEN(NUM_GEN),
    .SEL_HI_LSB(SEL_HI_LSB), .SEL_STRIDE(SEL_STRIDE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_code(sel_code), .ratio_pend(ratio_pend)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
    logic tick_en;

    aud_baud_src_sel u_sel (
      .src_tick(src_tick), .sel_code(sel_code[g]), .tick_en(tick_en)
    );

    aud_baud_div u_div (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .ratio_pend(ratio_pend[g]), .pulse(tick_out[g])
    );
  end
endmodule

// File: rtl/aud_baud_gen_chk.sv
`timescale 1ns/1ps
module aud_baud_gen_chk
  import aud_baud_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned NUM_GEN    = 2,
  parameter int unsigned SEL_HI_LSB = 20,
  parameter int unsigned SEL_STRIDE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [NUM_SRC-1:0] src_tick,
  input logic [NUM_GEN-1:0] tick_out
);
  logic [NUM_GEN-1:0][SRC_CODE_W-1:0] sel_seen;
  logic [NUM_GEN-1:0]                 sel_ok;
  logic [NUM_GEN-1:0]                 fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_seen <= '0;
    end else if (wr_en && wr_addr == '0) begin
      for (int g = 0; g < NUM_GEN; g++)
        sel_seen[g] <= wr_data[(SEL_HI_LSB - g * SEL_STRIDE) +: SRC_CODE_W];
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_GEN; g++) begin
      sel_ok[g] = map_src(sel_seen[g]).ok;
      fired[g]  = sel_ok[g] && src_tick[map_src(sel_seen[g]).idx];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (tick_out == '0)
        else $error("outputs active during reset");
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_prop
    p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick_out[g] |=> !tick_out[g]);
    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_out[g] |-> $past(fired[g]));
    p_gate_bad_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok[g] |=> !tick_out[g]);
  end
endmodule

bind aud_baud_gen aud_baud_gen_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_GEN(NUM_GEN),
  .SEL_HI_LSB(SEL_HI_LSB), .SEL_STRIDE(SEL_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .src_tick(src_tick), .tick_out(tick_out)
);

// File: tb/aud_baud_gen_tb.sv
`timescale 1ns/1ps
module aud_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  src_tick = '0;
  logic [1:0]  tick_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  aud_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_tick(src_tick), .tick_out(tick_out)
  );

  // ---------------- behavioural reference model ----------------
  int         m_cnt[2];
  logic [9:0] m_act[2];
  logic [9:0] m_shadow[2];
  logic [2:0] m_sel[2];
  logic [1:0] exp_tick;

  function automatic int src_index(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 1;
      3'd4: return 2;
      3'd2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int ratio_div(input logic [9:0] r);
    return (2 << (2 * int'(r[9:8]))) * (int'(r[7:0]) + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        m_cnt[g] = 0; m_act[g] = 10'd2; m_shadow[g] = 10'd2; m_sel[g] = 3'd0;
      end
      exp_tick = 2'b00;
    end else begin
      for (int g = 0; g < 2; g++) begin
        logic [9:0] nshadow;
        int         si;
        nshadow = (wr_en && wr_addr == 2'(g + 1)) ? wr_data[9:0] : m_shadow[g];
        si = src_index(m_sel[g]);
        exp_tick[g] = 1'b0;
        if (si >= 0 && src_tick[si]) begin
          m_cnt[g]++;
          if (m_cnt[g] == ratio_div(m_act[g])) begin
            exp_tick[g] = 1'b1;
            m_cnt[g] = 0;
            m_act[g] = nshadow;
          end
        end
        m_shadow[g] = nshadow;
      end
      if (wr_en && wr_addr == 2'd0) begin
        m_sel[0] = wr_data[22:20];
        m_sel[1] = wr_data[18:16];
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int g = 0; g < 2; g++) begin
        n_cmp++;
        if (tick_out[g] !== exp_tick[g]) begin
          n_bad++;
          $display("FAIL %s gen%0d at %0t: actual=%0b expected=%0b",
                   cur_req, g, $time, tick_out[g], exp_tick[g]);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  int dens[4] = '{100, 100, 100, 100};

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      for (int k = 0; k < 4; k++) src_tick[k] = (($urandom % 100) < dens[k]);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    for (int k = 0; k < 4; k++) src_tick[k] = (($urandom % 100) < dens[k]);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(1_900_000ns);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state; default divide by 6 on input 0 for both
    n_cmp++;
    if (tick_out !== 2'b00) begin
      n_bad++;
      $display("FAIL R1 reset outputs: actual=%b expected=00", tick_out);
    end
    rst_n = 1'b1;
    cur_req = "R1/R7";
    cycles(80);

    // R2/R8: several ratios, dense and sparse ticks
    cur_req = "R2/R8";
    write_reg(2'd1, {22'h3FFFFF, 2'd1, 8'd3});   // A: 8*4 = 32
    write_reg(2'd2, {22'd0, 2'd0, 8'd0});        // B: 2
    cycles(300);
    dens = '{50, 100, 100, 100};
    cycles(400);
    write_reg(2'd1, {22'd0, 2'd3, 8'd2});        // A: 128*3 = 384
    write_reg(2'd2, {22'd0, 2'd2, 8'd255});      // B: 32*256 = 8192
    dens = '{100, 100, 100, 100};
    cycles(17500);

    // R3/R4: field positions with junk bits, source mapping
    cur_req = "R3/R4";
    write_reg(2'd1, {22'd0, 2'd0, 8'd4});        // A: 10
    write_reg(2'd2, {22'd0, 2'd1, 8'd1});        // B: 16
    cycles(40);
    dens = '{20, 40, 60, 80};
    write_reg(2'd0, 32'hFF9C_FFFF);              // A code 1, B code 4
    cycles(600);
    write_reg(2'd0, 32'h0022_0000);              // both code 2 -> input 3
    cycles(600);
    write_reg(2'd0, 32'h0001_0000);              // A code 0, B code 1
    cycles(600);

    // R5: unlisted codes gate output, count held
    cur_req = "R5";
    write_reg(2'd0, 32'h0037_0000);              // A code 3, B code 7
    cycles(300);
    write_reg(2'd0, 32'h0056_0000);              // A code 5, B code 6
    cycles(300);
    write_reg(2'd0, 32'h0004_0000);              // A code 0, B code 4
    cycles(400);

    // R6: ratio rewrites mid count, some on terminal cycles
    cur_req = "R6/R8";
    dens = '{100, 100, 100, 100};
    write_reg(2'd1, {22'd0, 2'd0, 8'd1});
    for (int i = 0; i < 300; i++) begin
      write_reg(2'd1, {22'd0, 2'd0, 8'($urandom % 8)});
      if ((i % 3) == 0) write_reg(2'd2, {22'd0, 2'($urandom % 2), 8'($urandom % 4)});
      cycles($urandom % 5);
    end
    cycles(200);

    // R9: address 3 ignored, live source change keeps count
    cur_req = "R9";
    dens = '{60, 70, 80, 90};
    for (int i = 0; i < 200; i++) begin
      write_reg(2'd3, $urandom);
      cycles(3);
      if ((i % 25) == 0) write_reg(2'd0, {9'd0, 3'($urandom % 3), 1'b0, 3'($urandom % 3), 16'd0});
    end
    cycles(200);

    finish_run();
  end
endmodule